// File: doc/BRIEF.md
# Pixel-Array Strobe and Readout Sequencer

This block drives the control side of a CMOS pixel-array image sensor for one frame at a time. A start request is taken only while the block is idle. The block then runs one integration period. The period opens with a main pixel reset pulse. It may also hold several extra pulses that reset the pixels to a lower level at programmed offsets, which gives a dual-slope or multi-slope response. Next come a precharge strobe and a sample strobe. Last is a windowed readout: a frame sync and a row clock select each line, and a line sync and a pixel clock step across the columns.

All timing is counted in system clock cycles. A single programmed width `W` sets the length of every strobe. It also sets each half-period of the row and pixel clocks, so no pixel-array line changes faster than its slow on-chip drivers can follow. The pixels are read on both edges of the pixel clock, so a line of `C` columns takes `ceil(C/2)` pixel-clock periods. The configuration inputs are sampled once, in the cycle in which start is accepted. Changes made during a frame take effect at the next frame.

Top module: `pxg_readout_top`

## Requirements
- R1: `start` is accepted only while `busy` is low, and `busy` rises in the cycle after acceptance. A `start` pulse while `busy` is high is ignored and does not begin a second integration.
- R2: All `cfg_*` inputs are captured at acceptance, and changing them during a frame does not alter that frame. A width of 0 is used as 1, rows or columns of 0 are used as 1, and an integration length below `W` is used as `W`.
- R3: The integration period lasts `L` cycles, counted t = 0 .. L-1, and it starts in the cycle after acceptance. `pix_rst` (active high) is high for t < W only.
- R4: For each slot k with `cfg_ds_en[k]` set, the lower-level reset is requested for every t with ofs_k <= t < ofs_k + W and t < L. Here ofs_k is `cfg_ds_ofs[16k+15:16k]`, and requests from several slots combine by OR.
- R5: `pix_rst` has priority. In any cycle where both are requested, only `pix_rst` is high and `pix_rst_ds` is low.
- R6: After integration, `pix_prech_n` (active low) is low for W cycles. Then `pix_sample_n` (active low) is low for the next W cycles.
- R7: `pix_mem_hl` is 1 (high memory level) while idle, integrating, precharging and sampling. It is 0 (low level) exactly during the readout, which lasts 2W·(2 + R·(3 + ceil(C/2))) cycles.
- R8: The readout opens and closes with a `rd_sync_y` pulse one row-clock period wide. Between the two pulses there are exactly R rising edges of `rd_clk_y`, one for each line.
- R9: After each line's `rd_clk_y` period comes a `rd_sync_x` pulse one pixel-clock period wide. Then come ceil(C/2) `rd_clk_x` periods with `rd_sync_x` low, and then a closing `rd_sync_x` pulse. Each frame therefore has 2R line syncs.
- R10: Every high level of `pix_rst`, `rd_clk_x` and `rd_clk_y`, and every low level of `pix_sample_n` and `pix_prech_n`, lasts exactly W cycles.
- R11: `done` is high for one cycle, in the cycle after the last cycle of the closing `rd_sync_y`. `busy` falls in that same cycle, so `busy` is high for L + 2W + readout length cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Frame request, accepted when idle |
| cfg_integ_len | input | CNT_W | Integration length L in cycles |
| cfg_ds_ofs | input | NUM_DS*CNT_W | Lower-level reset offsets, slot k in bits [CNT_W*k +: CNT_W] |
| cfg_ds_en | input | NUM_DS | Enable for each lower-level reset slot |
| cfg_rows | input | CNT_W | Window rows R |
| cfg_cols | input | CNT_W | Window columns C |
| cfg_pulse_w | input | PW_W | Strobe width and clock half-period W |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| pix_rst | output | 1 | Main pixel reset, active high |
| pix_rst_ds | output | 1 | Lower-level pixel reset, active high |
| pix_prech_n | output | 1 | Precharge, active low |
| pix_sample_n | output | 1 | Sample, active low |
| pix_mem_hl | output | 1 | Memory level select, 1 = high |
| rd_sync_y | output | 1 | Frame sync, active high |
| rd_clk_y | output | 1 | Row clock, rising edge selects the next line |
| rd_sync_x | output | 1 | Line sync, active high |
| rd_clk_x | output | 1 | Pixel clock, both edges read a pixel |

## Verification
Some properties are checked on every cycle. `pix_rst` and `pix_rst_ds` are never high together. Each completed level of the main reset, the sample strobe and both readout clocks lasts exactly the captured width. The readout clocks and syncs appear only while the memory level is low. The two syncs never overlap. `done` is a single cycle that follows the fall of `busy`. Other properties need the bench's end-to-end scenarios, which count whole frames: the number of row and pixel clock edges for a given window, which cycles carry the lower-level reset (including offsets that overlap the main reset or run past the end of integration), the clamping of zero settings, that configuration changes during a frame have no effect, and the exact length of `busy`.

// File: rtl/pxg_pkg.sv
package pxg_pkg;
   // Order matters: the states after ST_SAMPLE form the readout.
   typedef enum logic [3:0] {
      ST_IDLE, ST_INTEG, ST_PRECH, ST_SAMPLE,
      ST_FSYNC, ST_ROWCK, ST_LSYNC, ST_PIXCK, ST_LEND, ST_FEND
   } pxg_state_t;

   localparam int unsigned PXG_NOUT = 11;
endpackage

// File: rtl/pxg_slot_timer.sv
// Counts slots of len cycles while enabled; last marks the final cycle of a slot.
module pxg_slot_timer #(
   parameter int unsigned PW_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic [PW_W-1:0] len,
   output logic            last
);
   localparam logic [PW_W-1:0] ONE_P = 1;
   logic [PW_W-1:0] cnt;

   assign last = en && (cnt == len - ONE_P);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (!en || last)   cnt <= '0;
      else                    cnt <= cnt + ONE_P;
   end
endmodule

// File: rtl/pxg_slope_gen.sv
// One window comparator for each lower-level reset slot, ORed together.
module pxg_slope_gen #(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned NUM_DS = 3,
   parameter int unsigned PW_W   = 8
) (
   input  logic [CNT_W-1:0]        t,
   input  logic [NUM_DS*CNT_W-1:0] ofs,
   input  logic [NUM_DS-1:0]       en,
   input  logic [PW_W-1:0]         w,
   output logic                    hit
);
   localparam int unsigned EW = CNT_W + 1;
   logic [NUM_DS-1:0] h;

   for (genvar k = 0; k < NUM_DS; k++) begin : g_slot
      logic [CNT_W-1:0] o_k;
      logic [EW-1:0]    end_k;
      assign o_k   = ofs[k*CNT_W +: CNT_W];
      assign end_k = {1'b0, o_k} + EW'(w);
      assign h[k]  = en[k] && (t >= o_k) && ({1'b0, t} < end_k);
   end

   assign hit = |h;
endmodule

// File: rtl/pxg_readout_top.sv
module pxg_readout_top
   import pxg_pkg::*;
#(
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned NUM_DS  = 3,
   parameter int unsigned PW_W    = 8,
   parameter bit          REG_OUT = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic [CNT_W-1:0]        cfg_integ_len,
   input  logic [NUM_DS*CNT_W-1:0] cfg_ds_ofs,
   input  logic [NUM_DS-1:0]       cfg_ds_en,
   input  logic [CNT_W-1:0]        cfg_rows,
   input  logic [CNT_W-1:0]        cfg_cols,
   input  logic [PW_W-1:0]         cfg_pulse_w,
   output logic                    busy,
   output logic                    done,
   output logic                    pix_rst,
   output logic                    pix_rst_ds,
   output logic                    pix_prech_n,
   output logic                    pix_sample_n,
   output logic                    pix_mem_hl,
   output logic                    rd_sync_y,
   output logic                    rd_clk_y,
   output logic                    rd_sync_x,
   output logic                    rd_clk_x
);
   localparam logic [CNT_W-1:0]    ONE_C   = 1;
   localparam logic [PW_W-1:0]     ONE_P   = 1;
   localparam logic [PXG_NOUT-1:0] OUT_RST = 11'b000_0111_0000;

   if (NUM_DS < 1) begin : g_bad_ds
      $error("pxg_readout_top: NUM_DS must be at least 1");
   end
   if (PW_W < 1 || PW_W > CNT_W) begin : g_bad_pw
      $error("pxg_readout_top: PW_W must be in 1..CNT_W");
   end

   pxg_state_t              state;
   logic [PW_W-1:0]         w_q;
   logic [CNT_W-1:0]        len_q, rows_q, pairs_q, t_q, row_q, pair_q;
   logic [NUM_DS*CNT_W-1:0] ofs_q;
   logic [NUM_DS-1:0]       en_q;
   logic                    half_q, done_q;

   // Clamped settings, taken at acceptance
   logic [PW_W-1:0]  w_eff;
   logic [CNT_W-1:0] len_eff, rows_eff, cols_eff, pairs_eff;
   assign w_eff     = (cfg_pulse_w == '0) ? ONE_P : cfg_pulse_w;
   assign len_eff   = (cfg_integ_len < CNT_W'(w_eff)) ? CNT_W'(w_eff) : cfg_integ_len;
   assign rows_eff  = (cfg_rows == '0) ? ONE_C : cfg_rows;
   assign cols_eff  = (cfg_cols == '0) ? ONE_C : cfg_cols;
   assign pairs_eff = (cols_eff >> 1) + CNT_W'(cols_eff[0]);

   logic slot_en, slot_last, ds_hit;
   assign slot_en = (state != ST_IDLE) && (state != ST_INTEG);

   pxg_slot_timer #(.PW_W(PW_W)) u_slot (
      .clk(clk), .rst_n(rst_n), .en(slot_en), .len(w_q), .last(slot_last)
   );

   pxg_slope_gen #(.CNT_W(CNT_W), .NUM_DS(NUM_DS), .PW_W(PW_W)) u_slope (
      .t(t_q), .ofs(ofs_q), .en(en_q), .w(w_q), .hit(ds_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         w_q     <= ONE_P;
         len_q   <= ONE_C;
         rows_q  <= ONE_C;
         pairs_q <= ONE_C;
         ofs_q   <= '0;
         en_q    <= '0;
         t_q     <= '0;
         row_q   <= '0;
         pair_q  <= '0;
         half_q  <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state)
            ST_IDLE: if (start) begin
               w_q     <= w_eff;
               len_q   <= len_eff;
               rows_q  <= rows_eff;
               pairs_q <= pairs_eff;
               ofs_q   <= cfg_ds_ofs;
               en_q    <= cfg_ds_en;
               t_q     <= '0;
               state   <= ST_INTEG;
            end
            ST_INTEG: if (t_q == len_q - ONE_C) state <= ST_PRECH;
                      else t_q <= t_q + ONE_C;
            ST_PRECH: if (slot_last) state <= ST_SAMPLE;
            ST_SAMPLE: if (slot_last) begin
               state  <= ST_FSYNC;
               half_q <= 1'b0;
            end
            default: if (slot_last) begin
               half_q <= ~half_q;
               if (half_q) begin
                  case (state)
                     ST_FSYNC: begin state <= ST_ROWCK; row_q <= '0; end
                     ST_ROWCK: state <= ST_LSYNC;
                     ST_LSYNC: begin state <= ST_PIXCK; pair_q <= '0; end
                     ST_PIXCK: if (pair_q == pairs_q - ONE_C) state <= ST_LEND;
                               else pair_q <= pair_q + ONE_C;
                     ST_LEND: if (row_q == rows_q - ONE_C) state <= ST_FEND;
                              else begin row_q <= row_q + ONE_C; state <= ST_ROWCK; end
                     ST_FEND: begin state <= ST_IDLE; done_q <= 1'b1; end
                     default: state <= ST_IDLE;
                  endcase
               end
            end
         endcase
      end
   end

   // Output decode
   logic rst_c, ds_c, ro_c, ycyc_c, xcyc_c;
   assign rst_c  = (state == ST_INTEG) && (t_q < CNT_W'(w_q));
   assign ds_c   = (state == ST_INTEG) && ds_hit && !rst_c;
   assign ro_c   = (state == ST_FSYNC) || (state == ST_ROWCK) || (state == ST_LSYNC) ||
                   (state == ST_PIXCK) || (state == ST_LEND)  || (state == ST_FEND);
   assign ycyc_c = (state == ST_FSYNC) || (state == ST_ROWCK) || (state == ST_FEND);
   assign xcyc_c = (state == ST_LSYNC) || (state == ST_PIXCK) || (state == ST_LEND);

   logic [PXG_NOUT-1:0] out_c, out_q;
   assign out_c = {(state != ST_IDLE), done_q, rst_c, ds_c,
                   (state != ST_PRECH), (state != ST_SAMPLE), !ro_c,
                   (state == ST_FSYNC) || (state == ST_FEND), ycyc_c && half_q,
                   (state == ST_LSYNC) || (state == ST_LEND), xcyc_c && half_q};

   if (REG_OUT) begin : g_reg_out
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) out_q <= OUT_RST;
         else        out_q <= out_c;
      end
   end else begin : g_comb_out
      assign out_q = out_c;
   end

   assign {busy, done, pix_rst, pix_rst_ds, pix_prech_n, pix_sample_n, pix_mem_hl,
           rd_sync_y, rd_clk_y, rd_sync_x, rd_clk_x} = out_q;
endmodule

// File: rtl/pxg_readout_chk.sv
module pxg_readout_chk #(
   parameter int unsigned PW_W = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            busy,
   input logic            done,
   input logic            pix_rst,
   input logic            pix_rst_ds,
   input logic            pix_prech_n,
   input logic            pix_sample_n,
   input logic            pix_mem_hl,
   input logic            rd_sync_y,
   input logic            rd_clk_y,
   input logic            rd_sync_x,
   input logic            rd_clk_x,
   input logic [PW_W-1:0] w_q
);
   logic [15:0] rst_run, smp_run, pre_run, cx_run, cy_run, w16;
   assign w16 = 16'(w_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_run <= '0; smp_run <= '0; pre_run <= '0; cx_run <= '0; cy_run <= '0;
      end else begin
         rst_run <= pix_rst       ? rst_run + 16'd1 : '0;
         smp_run <= !pix_sample_n ? smp_run + 16'd1 : '0;
         pre_run <= !pix_prech_n  ? pre_run + 16'd1 : '0;
         cx_run  <= rd_clk_x      ? cx_run  + 16'd1 : '0;
         cy_run  <= rd_clk_y      ? cy_run  + 16'd1 : '0;
      end
   end

   // R5
   rst_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(pix_rst && pix_rst_ds));
   // R10
   rst_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pix_rst) |-> rst_run == w16);
   // R6
   smp_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pix_sample_n) |-> smp_run == w16);
   // R6
   pre_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pix_prech_n) |-> pre_run == w16);
   // R10
   clkx_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_clk_x) |-> cx_run == w16);
   // R10
   clky_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_clk_y) |-> cy_run == w16);
   // R7
   ro_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clk_x || rd_clk_y || rd_sync_x || rd_sync_y) |-> !pix_mem_hl);
   // R7
   smp_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_sample_n |-> pix_mem_hl);
   // R9
   sync_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_sync_x && rd_sync_y));
   // R11
   done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));
   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

bind pxg_readout_top pxg_readout_chk #(.PW_W(PW_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .pix_rst(pix_rst),
   .pix_rst_ds(pix_rst_ds), .pix_prech_n(pix_prech_n), .pix_sample_n(pix_sample_n),
   .pix_mem_hl(pix_mem_hl), .rd_sync_y(rd_sync_y), .rd_clk_y(rd_clk_y),
   .rd_sync_x(rd_sync_x), .rd_clk_x(rd_clk_x), .w_q(w_q)
);

// File: tb/pxg_readout_top_tb.sv
module pxg_readout_top_tb;
   localparam int CLK_PERIOD = 10;
   localparam int CNT_W = 16;
   localparam int NUM_DS = 3;
   localparam int PW_W = 8;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic [CNT_W-1:0] cfg_integ_len = '0, cfg_rows = '0, cfg_cols = '0;
   logic [NUM_DS*CNT_W-1:0] cfg_ds_ofs = '0;
   logic [NUM_DS-1:0] cfg_ds_en = '0;
   logic [PW_W-1:0] cfg_pulse_w = '0;
   logic busy, done, pix_rst, pix_rst_ds, pix_prech_n, pix_sample_n, pix_mem_hl;
   logic rd_sync_y, rd_clk_y, rd_sync_x, rd_clk_x;

   int checks = 0, errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pxg_readout_top #(.CNT_W(CNT_W), .NUM_DS(NUM_DS), .PW_W(PW_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .cfg_integ_len(cfg_integ_len),
      .cfg_ds_ofs(cfg_ds_ofs), .cfg_ds_en(cfg_ds_en), .cfg_rows(cfg_rows),
      .cfg_cols(cfg_cols), .cfg_pulse_w(cfg_pulse_w), .busy(busy), .done(done),
      .pix_rst(pix_rst), .pix_rst_ds(pix_rst_ds), .pix_prech_n(pix_prech_n),
      .pix_sample_n(pix_sample_n), .pix_mem_hl(pix_mem_hl), .rd_sync_y(rd_sync_y),
      .rd_clk_y(rd_clk_y), .rd_sync_x(rd_sync_x), .rd_clk_x(rd_clk_x)
   );

   // Frame monitor, sampling at the falling edge
   int m_rst_hi, m_rst_rise, m_ds_hi, m_pre_lo, m_smp_lo, m_mem_lo, m_sy_rise;
   int m_cy_rise, m_sx_rise, m_cx_rise, m_busy, m_done, m_smp_memlo, m_pre_at_smp;
   logic p_rst = 0, p_sy = 0, p_cy = 0, p_sx = 0, p_cx = 0, p_smp = 1;

   task automatic clear_mon();
      m_rst_hi = 0; m_rst_rise = 0; m_ds_hi = 0; m_pre_lo = 0; m_smp_lo = 0;
      m_mem_lo = 0; m_sy_rise = 0; m_cy_rise = 0; m_sx_rise = 0; m_cx_rise = 0;
      m_busy = 0; m_done = 0; m_smp_memlo = 0; m_pre_at_smp = -1;
   endtask

   always @(negedge clk) if (rst_n) begin
      if (pix_rst) m_rst_hi++;
      if (pix_rst && !p_rst) m_rst_rise++;
      if (pix_rst_ds) m_ds_hi++;
      if (!pix_prech_n) m_pre_lo++;
      if (!pix_sample_n) m_smp_lo++;
      if (!pix_sample_n && p_smp) m_pre_at_smp = m_pre_lo;
      if (!pix_sample_n && !pix_mem_hl) m_smp_memlo++;
      if (!pix_mem_hl) m_mem_lo++;
      if (rd_sync_y && !p_sy) m_sy_rise++;
      if (rd_clk_y && !p_cy && !rd_sync_y) m_cy_rise++;
      if (rd_sync_x && !p_sx) m_sx_rise++;
      if (rd_clk_x && !p_cx && !rd_sync_x) m_cx_rise++;
      if (busy) m_busy++;
      if (done) m_done++;
      p_rst = pix_rst; p_sy = rd_sync_y; p_cy = rd_clk_y; p_sx = rd_sync_x;
      p_cx = rd_clk_x; p_smp = pix_sample_n;
   end

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Expected lower-level reset cycles: R4 windows minus R5 overlap with the main reset
   function automatic int exp_ds(int l, int w, logic [NUM_DS*CNT_W-1:0] ofs,
                                 logic [NUM_DS-1:0] en);
      int n = 0;
      for (int t = 0; t < l; t++) begin
         bit h = 0;
         for (int k = 0; k < NUM_DS; k++) begin
            int o = int'(ofs[k*CNT_W +: CNT_W]);
            if (en[k] && t >= o && t < o + w) h = 1;
         end
         if (h && t >= w) n++;
      end
      return n;
   endfunction

   function automatic int exp_ro(int w, int r, int c);
      return 2 * w * (2 + r * (3 + (c + 1) / 2));
   endfunction

   // Runs one frame; optionally disturbs the config and pulses start mid-frame
   task automatic run_frame(int l, int w, int r, int c, logic [NUM_DS*CNT_W-1:0] ofs,
                            logic [NUM_DS-1:0] en, bit disturb);
      int we, le, re, ce, guard;
      we = (w == 0) ? 1 : w;
      le = (l < we) ? we : l;
      re = (r == 0) ? 1 : r;
      ce = (c == 0) ? 1 : c;
      @(negedge clk);
      clear_mon();
      cfg_integ_len = CNT_W'(l); cfg_pulse_w = PW_W'(w); cfg_rows = CNT_W'(r);
      cfg_cols = CNT_W'(c); cfg_ds_ofs = ofs; cfg_ds_en = en;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      // R1 / R3: busy and main reset begin in the cycle after acceptance
      chk("R1", "busy after start", int'(busy), 1);
      chk("R3", "pix_rst at t=0", int'(pix_rst), 1);
      if (disturb) begin
         repeat (3) @(negedge clk);
         cfg_integ_len = CNT_W'(l + 9); cfg_pulse_w = PW_W'(we + 2);
         cfg_rows = CNT_W'(re + 1); cfg_cols = CNT_W'(ce + 3);
         cfg_ds_en = ~en; cfg_ds_ofs = ~ofs;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      guard = 0;
      while (!done && guard < 20000) begin @(negedge clk); guard++; end
      @(negedge clk);
      chk("R3", "main reset cycles", m_rst_hi, we);
      chk("R1", "main reset pulses (single frame)", m_rst_rise, 1);
      chk("R4", "lower-level reset cycles", m_ds_hi, exp_ds(le, we, ofs, en));
      chk("R6", "precharge low cycles", m_pre_lo, we);
      chk("R6", "sample low cycles", m_smp_lo, we);
      chk("R6", "precharge done before sample", m_pre_at_smp, we);
      chk("R7", "mem low during sample", m_smp_memlo, 0);
      chk("R7", "mem low cycles", m_mem_lo, exp_ro(we, re, ce));
      chk("R8", "frame sync pulses", m_sy_rise, 2);
      chk("R8", "row clock edges", m_cy_rise, re);
      chk("R9", "line sync pulses", m_sx_rise, 2 * re);
      chk("R9", "pixel clock periods", m_cx_rise, re * ((ce + 1) / 2));
      chk("R11", "busy cycles", m_busy, le + 2 * we + exp_ro(we, re, ce));
      chk("R11", "done pulses", m_done, 1);
      chk("R2", "frame finished", int'(guard < 20000), 1);
      cfg_integ_len = '0; cfg_ds_en = '0;
   endtask

   function automatic logic [NUM_DS*CNT_W-1:0] pack3(int a, int b, int c);
      return {CNT_W'(c), CNT_W'(b), CNT_W'(a)};
   endfunction

   initial begin
      #(CLK_PERIOD * 190000);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      clear_mon();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // Reset state (R1, R7)
      chk("R1", "busy idle", int'(busy), 0);
      chk("R11", "done idle", int'(done), 0);
      chk("R7", "mem level idle", int'(pix_mem_hl), 1);
      chk("R6", "strobes idle", int'({pix_rst, pix_rst_ds, pix_prech_n, pix_sample_n}), 4'b0011);
      chk("R8", "readout lines idle", int'({rd_sync_y, rd_clk_y, rd_sync_x, rd_clk_x}), 0);

      // Directed corners
      run_frame(20, 3, 2, 4, pack3(1, 8, 15), 3'b111, 1'b0); // R5 slot 0 overlaps main reset
      run_frame(12, 2, 1, 5, pack3(11, 4, 5), 3'b011, 1'b0); // R4 slot 0 runs past L, odd cols
      run_frame(10, 0, 0, 0, pack3(3, 0, 0), 3'b001, 1'b0);  // R2 zero width/rows/cols
      run_frame(1, 3, 1, 2, pack3(0, 1, 2), 3'b111, 1'b0);   // R2 L below W, all hidden by R5
      run_frame(25, 2, 2, 3, pack3(6, 12, 18), 3'b101, 1'b1); // R1/R2 mid-frame disturbance

      // Constrained random frames (R4, R8, R9, R10)
      for (int i = 0; i < 12; i++) begin
         int l = 5 + int'($urandom_range(35));
         int w = 1 + int'($urandom_range(2));
         int r = 1 + int'($urandom_range(2));
         int c = 1 + int'($urandom_range(5));
         run_frame(l, w, r, c,
                   pack3(int'($urandom_range(l)), int'($urandom_range(l)), int'($urandom_range(l))),
                   3'($urandom_range(7)), 1'(i % 4 == 3));
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule